// File: doc/BRIEF.md
# Software Interrupt Dispatch Unit

This block takes a 64-bit software interrupt request word written by one core. It works out which of `NCORE` cores must receive that interrupt. For each receiving core it raises a one-cycle pending-set strobe tagged with the interrupt number. A request names its targets in one of two ways:

- **Directed:** an affinity triple plus a 16-bit mask over the lowest affinity level.
- **Broadcast:** every core except the requester.

The unit walks the cores one per clock in ascending order. On each step it compares the core's affinity with the request. In directed mode it stops as soon as every requested mask bit has been consumed. A target whose interrupt is configured as group 1 is only strobed when the request carries permission for group 1.

The unit is used next to a bank of per-core pending registers. The register bank ORs `pend_set[k]` into bit `pend_id` of core k. Requests are accepted only while the unit is idle. `busy` and `done` let the writer pace further requests.

Top module: `sgi_dispatch`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy`, `done` and `pend_set` are all zero.
- R2: The request word is decoded with these field positions: interrupt number in [27:24], level-0 mask in [15:0], level-1 affinity in [23:16], level-2 affinity in [39:32], broadcast bit 40, level-3 affinity in [55:48]. The `pend_id` output carries the interrupt number with every strobe.
- R3: In directed mode (bit 40 = 0), core k is a target exactly when its affinity levels 1, 2 and 3 all equal the request's, its level-0 affinity is below 16, and the mask bit indexed by its level-0 affinity is set. Each core's `core_aff` slice is packed as {aff3, aff2, aff1, aff0}, one byte each, with aff0 in the low byte.
- R4: In broadcast mode (bit 40 = 1), every core except the one named by `req_src` is a target.
- R5: Bit k*16+n of `core_grp1` set means interrupt n is group 1 on core k. Such a target is strobed only if `req_grp1_ok` was high when the request was accepted; otherwise it is passed over without a strobe. A group-0 target is always strobed.
- R6: Core k is evaluated on the (k+1)-th clock edge after the accepting edge. Its strobe appears on `pend_set[k]` after that edge, and at most one strobe bit is high in any cycle.
- R7: In directed mode, the scan ends on the step where the working mask becomes zero. A request whose mask is zero at acceptance ends on the first step, with no strobe.
- R8: `busy` rises on the edge after `req_valid` is seen while idle, and stays high until the final step. `done` is a one-cycle pulse that coincides with `busy` falling. A `req_valid` seen while busy is ignored.
- R9: A broadcast request never ends early; it always steps through all `NCORE` cores.
- R10: A directed target whose strobe is suppressed by the group filter still clears its mask bit, so it still counts toward the early end of the scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_word | input | 64 | Encoded software interrupt request |
| req_src | input | IDX_W | Index of the requesting core |
| req_grp1_ok | input | 1 | Group-1 interrupts may be raised by this request |
| core_aff | input | NCORE*32 | Per-core affinity, {aff3,aff2,aff1,aff0} per slice |
| core_grp1 | input | NCORE*16 | Per-core, per-interrupt group-1 configuration |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at the final scan step |
| pend_set | output | NCORE | One-hot pending-set strobe per core |
| pend_id | output | 4 | Interrupt number that goes with the strobe |

## Verification
The bench models each request as a list of per-cycle expected outputs and compares every clock.

- **Early exit.** A design that missed the early exit, or that took it in broadcast mode, would hold `busy` a different number of cycles.
- **Mask clearing under the group filter.** A design that left the mask bit set for a filtered target would scan past it instead of ending there.
- **Broadcast from the requester.** A broadcast that strobed the requester would show an extra bit.
- **Single-field mismatches.** A request differing from a core in only level 2 or level 3 affinity would expose a decoder using the wrong field position.
- **Request during a scan.** A second request issued mid-scan would corrupt the sequence if it were not ignored.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

  localparam int MASK_W = 16;
  localparam int ID_W   = 4;
  localparam int AFF_W  = 8;
  localparam int SLICE_W = 4 * AFF_W;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              bcast;
    logic [MASK_W-1:0] mask;
    logic [AFF_W-1:0]  a1;
    logic [AFF_W-1:0]  a2;
    logic [AFF_W-1:0]  a3;
  } sgi_req_t;

  function automatic sgi_req_t decode_req(input logic [63:0] w);
    sgi_req_t r;
    r.id    = w[27:24];
    r.bcast = w[40];
    r.mask  = w[15:0];
    r.a1    = w[23:16];
    r.a2    = w[39:32];
    r.a3    = w[55:48];
    return r;
  endfunction

endpackage

// File: rtl/sgi_target_match.sv
module sgi_target_match
  import sgi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  sgi_req_t            req,
  input  logic [MASK_W-1:0]   work_mask,
  input  logic [IDX_W-1:0]    src_idx,
  input  logic [IDX_W-1:0]    cur_idx,
  input  logic [SLICE_W-1:0]  aff,
  input  logic                grp1_bit,
  input  logic                grp1_ok,
  output logic                deliver,
  output logic [MASK_W-1:0]   clr_mask
);
  logic [AFF_W-1:0] a0, a1, a2, a3;
  logic             l0_in_range, upper_eq, dir_hit, bc_hit;

  assign a0 = aff[AFF_W-1:0];
  assign a1 = aff[2*AFF_W-1:AFF_W];
  assign a2 = aff[3*AFF_W-1:2*AFF_W];
  assign a3 = aff[4*AFF_W-1:3*AFF_W];

  assign l0_in_range = (a0[AFF_W-1:4] == '0);
  assign upper_eq    = (a1 == req.a1) && (a2 == req.a2) && (a3 == req.a3);

  always_comb begin
    dir_hit  = !req.bcast && upper_eq && l0_in_range && work_mask[a0[3:0]];
    bc_hit   = req.bcast && (cur_idx != src_idx);
    clr_mask = dir_hit ? (MASK_W'(1) << a0[3:0]) : '0;
    deliver  = (dir_hit || bc_hit) && (!grp1_bit || grp1_ok);
  end
endmodule

// File: rtl/sgi_scan_seq.sv
module sgi_scan_seq #(
  parameter int NCORE = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             finish,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NCORE - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end
    end else if (finish) begin
      busy <= 1'b0;
    end else begin
      idx <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NCORE = 8,
  localparam int IDX_W = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [63:0]              req_word,
  input  logic [IDX_W-1:0]         req_src,
  input  logic                     req_grp1_ok,
  input  logic [NCORE*SLICE_W-1:0] core_aff,
  input  logic [NCORE*MASK_W-1:0]  core_grp1,
  output logic                     busy,
  output logic                     done,
  output logic [NCORE-1:0]         pend_set,
  output logic [ID_W-1:0]          pend_id
);
  sgi_req_t           req_q;
  logic [MASK_W-1:0]  mask_q, mask_nx, clr_mask;
  logic [IDX_W-1:0]   src_q, idx;
  logic               grp1_q, bcast_q;
  logic               accept, at_last, finish, deliver;
  logic [SLICE_W-1:0] cur_aff;
  logic [MASK_W-1:0]  cur_grp;

  assign accept  = req_valid && !busy;
  assign bcast_q = req_q.bcast;
  assign cur_aff = core_aff[idx*SLICE_W +: SLICE_W];
  assign cur_grp = core_grp1[idx*MASK_W +: MASK_W];
  assign mask_nx = mask_q & ~clr_mask;
  assign finish  = busy && (at_last || (!bcast_q && mask_nx == '0));

  sgi_scan_seq #(.NCORE(NCORE), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .finish(finish),
    .busy(busy), .idx(idx), .at_last(at_last)
  );

  sgi_target_match #(.IDX_W(IDX_W)) u_match (
    .req(req_q), .work_mask(mask_q), .src_idx(src_q), .cur_idx(idx),
    .aff(cur_aff), .grp1_bit(cur_grp[req_q.id]), .grp1_ok(grp1_q),
    .deliver(deliver), .clr_mask(clr_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      mask_q <= '0;
      src_q  <= '0;
      grp1_q <= 1'b0;
    end else if (accept) begin
      req_q  <= decode_req(req_word);
      mask_q <= decode_req(req_word).mask;
      src_q  <= req_src;
      grp1_q <= req_grp1_ok;
    end else if (busy) begin
      mask_q <= mask_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      pend_set <= '0;
      pend_id  <= '0;
    end else begin
      done     <= finish;
      pend_set <= (busy && deliver) ? (NCORE'(1) << idx) : '0;
      pend_id  <= req_q.id;
    end
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NCORE = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic [NCORE-1:0] pend_set,
  input logic [IDX_W-1:0] src_q,
  input logic             bcast_q
);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pend_set));

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r8_done_follows_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  a_r8_start_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

  a_r6_strobe_in_scan: assert property (@(posedge clk) disable iff (rst)
    (pend_set != '0) |-> $past(busy));

  a_r4_skip_source: assert property (@(posedge clk) disable iff (rst)
    ((pend_set != '0) && bcast_q) |-> !pend_set[src_q]);
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NCORE(NCORE), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .busy(busy), .done(done),
  .pend_set(pend_set), .src_q(src_q), .bcast_q(bcast_q)
);

// File: tb/tb_sgi_dispatch.sv
`timescale 1ns/1ps
module tb_sgi_dispatch;
  localparam int NC = 8;
  localparam int IW = 3;

  logic              clk = 0, rst = 1, req_valid = 0, req_grp1_ok = 0;
  logic [63:0]       req_word = '0;
  logic [IW-1:0]     req_src = '0;
  logic [NC*32-1:0]  core_aff;
  logic [NC*16-1:0]  core_grp1;
  logic              busy, done;
  logic [NC-1:0]     pend_set;
  logic [3:0]        pend_id;

  always #4 clk = ~clk;

  sgi_dispatch #(.NCORE(NC)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_word(req_word),
    .req_src(req_src), .req_grp1_ok(req_grp1_ok), .core_aff(core_aff),
    .core_grp1(core_grp1), .busy(busy), .done(done), .pend_set(pend_set),
    .pend_id(pend_id));

  typedef struct { logic [NC-1:0] pend; bit dn; bit bz; int id; } exp_t;
  exp_t q[$];
  exp_t e;
  int checks = 0, errors = 0;
  string tag = "R1";
  bit running = 0, finished = 0;

  function automatic logic [63:0] mk(int id, bit bc, int mask, int a1, int a2, int a3);
    logic [63:0] w = '0;
    w[27:24] = id[3:0]; w[40] = bc; w[15:0] = mask[15:0];
    w[23:16] = a1[7:0]; w[39:32] = a2[7:0]; w[55:48] = a3[7:0];
    return w;
  endfunction

  task automatic plan_request();
    int id = int'(req_word[27:24]);
    bit bc = req_word[40];
    int mask = int'(req_word[15:0]);
    for (int k = 0; k < NC; k++) begin
      exp_t x;
      int a0 = int'(core_aff[k*32 +: 8]);
      bit hit;
      if (bc) hit = (k != int'(req_src));
      else hit = (core_aff[k*32+8 +: 24] == {req_word[55:48], req_word[39:32], req_word[23:16]})
                 && a0 < 16 && mask[a0];
      if (!bc && hit) mask = mask & ~(1 << a0);
      x.pend = (hit && (!core_grp1[k*16+id] || req_grp1_ok)) ? NC'(1) << k : '0;
      x.dn = (k == NC-1) || (!bc && mask == 0);
      x.bz = !x.dn;
      x.id = id;
      q.push_back(x);
      if (x.dn) break;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); e.pend = '0; e.dn = 0; e.bz = 0; e.id = 0;
    end else if (q.size() > 0) begin
      e = q.pop_front();
    end else if (req_valid) begin
      plan_request();
      e.pend = '0; e.dn = 0; e.bz = 1; e.id = 0;
    end else begin
      e.pend = '0; e.dn = 0; e.bz = 0; e.id = 0;
    end
  end

  task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      chk(tag, "busy", 32'(busy), 32'(e.bz));
      chk(tag, "done", 32'(done), 32'(e.dn));
      chk(tag, "pend_set", 32'(pend_set), 32'(e.pend));
      if (e.pend != '0) chk(tag, "pend_id", 32'(pend_id), 32'(e.id));
    end
  end

  task automatic send(logic [63:0] w, int src, bit g1, string t);
    @(negedge clk);
    tag = t; req_word = w; req_src = src[IW-1:0]; req_grp1_ok = g1; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (e.bz || q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      logic [7:0] a0 = (k < 4) ? 8'(k) : 8'(k - 4);
      logic [7:0] a1 = (k < 4) ? 8'd1 : 8'd2;
      logic [7:0] a3 = (k == 7) ? 8'd8 : 8'd7;
      core_aff[k*32 +: 32] = {a3, 8'd5, a1, a0};
    end
    core_grp1 = '0;
    core_grp1[2*16 + 3] = 1'b1;
    core_grp1[5*16 + 1] = 1'b1;

    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 32'(busy), 0);
    chk("R1", "done in reset", 32'(done), 0);
    chk("R1", "pend in reset", 32'(pend_set), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "pend after reset", 32'(pend_set), 0);
    running = 1;

    send(mk(5, 0, 16'h000A, 1, 5, 7), 0, 0, "R3");
    send(mk(9, 0, 16'h0001, 2, 5, 7), 6, 0, "R2");
    send(mk(4, 0, 16'h000F, 1, 6, 7), 0, 0, "R2");
    send(mk(1, 1, 0, 0, 0, 0), 2, 1, "R4");
    send(mk(1, 1, 16'hFFFF, 1, 5, 7), 2, 0, "R5");
    send(mk(7, 1, 0, 0, 0, 0), 0, 0, "R9");
    send(mk(3, 0, 16'h0004, 1, 5, 7), 1, 0, "R10");
    send(mk(3, 0, 16'h0004, 1, 5, 7), 1, 1, "R5");
    send(mk(6, 0, 16'h0000, 1, 5, 7), 3, 0, "R7");
    send(mk(2, 0, 16'h8009, 2, 5, 7), 3, 0, "R6");
    send(mk(11, 0, 16'h0008, 2, 5, 8), 0, 0, "R3");

    @(negedge clk);
    tag = "R8"; req_word = mk(12, 1, 0, 0, 0, 0); req_src = 3'd4; req_grp1_ok = 1; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    repeat (3) @(negedge clk);
    req_word = mk(13, 0, 16'h0001, 1, 5, 7); req_src = 3'd1; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (e.bz || q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8", "idle after ignored request", 32'(busy), 0);

    finish_run();
  end
endmodule